// File: doc/BRIEF.md
# Cascade Bus Master Handshake

This block sits in an add-in card that wants to become master of the system bus. The system DMA controller has a channel set to cascade mode for this card. When local logic asks for the bus, the block raises the DMA request line. It waits for the active-low acknowledge, and then claims the bus by pulling the active-low master line low. It opens the address/data drive enable one clock later and the read/write command enable one clock after that.

The bus is held while the local request stays asserted. A tenure counter forces a release before the hold limit, because memory refresh stops while the card owns the bus. Release is a fixed four-clock sequence: commands stop first, then address/data drive stops, then the master line returns high, and then the DMA request drops. A new request is raised only once the acknowledge has gone inactive again.

The hold limit is the parameter `HOLD_LIMIT`, counted in clocks. It must be at least 5. The default is 120, which is 15 microseconds at an 8 MHz bus clock. Reset is synchronous and active high.

Top module: `cascade_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dreq` is 0 and `master_n`, `adr_drive` and `cmd_allow` are at their idle values 1, 0 and 0.
- R2: From idle, with `want_bus` at 1 and `dack_n` at 1 before a clock edge, `dreq` is 1 after that edge.
- R3: Once raised, `dreq` stays 1 until `dack_n` has been sampled at 0, even if `want_bus` falls in the meantime.
- R4: While requesting, a `dack_n` of 0 at a clock edge drives `master_n` to 0 after that edge, with `adr_drive` and `cmd_allow` still 0.
- R5: `adr_drive` is 1 only when `master_n` has been 0 for at least one full clock before; it rises exactly one clock after `master_n` falls.
- R6: `cmd_allow` is 1 only when `master_n` has been 0 for at least two full clocks; it rises exactly two clocks after `master_n` falls while `want_bus` stays 1.
- R7: `master_n` is never 0 for more than `HOLD_LIMIT` consecutive clocks. With `want_bus` held at 1, it is 0 for exactly `HOLD_LIMIT` clocks.
- R8: Release runs in this order, each step on its own clock: `cmd_allow` falls, then `adr_drive` falls, then `master_n` rises, then `dreq` falls.
- R9: After a release, `dreq` stays 0 while `dack_n` is 0. It rises again only after an edge at which `dack_n` is 1 and `want_bus` is 1.
- R10: `want_bus` sampled at 0 while the bus is held starts the release, so `cmd_allow` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| want_bus | input | 1 | Local request to own the bus |
| dack_n | input | 1 | DMA acknowledge from the cascade channel, active low |
| dreq | output | 1 | DMA request to the cascade channel, active high |
| master_n | output | 1 | Bus master claim, active low |
| adr_drive | output | 1 | Enable for driving address and data lines |
| cmd_allow | output | 1 | Enable for issuing read or write commands |

## Verification
The in-RTL properties cover the timing rules on every cycle:
- address drive and commands are never enabled before one and two clocks of master ownership;
- the master line never stays low past the hold limit;
- the release steps never overlap;
- a new request never rises while the acknowledge is still active.

Some behaviours can only be shown by the bench's scenarios:
- the exact clock at which each enable opens;
- the hold time equalling the limit when the local request stays high;
- a request that survives a drop of the local request before the acknowledge;
- a prompt release when the local request falls.

// File: rtl/cascade_master.sv
module cascade_master #(
  parameter int HOLD_LIMIT = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic want_bus,
  input  logic dack_n,
  output logic dreq,
  output logic master_n,
  output logic adr_drive,
  output logic cmd_allow
);

  localparam int CW = $clog2(HOLD_LIMIT + 1);
  localparam logic [CW-1:0] LAST_HELD = CW'(HOLD_LIMIT - 3);

  typedef enum logic [2:0] {
    S_IDLE, S_ASK, S_HELD, S_NOCMD, S_NOADR, S_FREE
  } st_t;

  st_t st, nx;
  logic [CW-1:0] held;

  always_comb begin
    nx = st;
    case (st)
      S_IDLE:  if (want_bus && dack_n) nx = S_ASK;
      S_ASK:   if (!dack_n) nx = S_HELD;
      S_HELD:  if (!want_bus || held == LAST_HELD) nx = S_NOCMD;
      S_NOCMD: nx = S_NOADR;
      S_NOADR: nx = S_FREE;
      S_FREE:  nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      held <= '0;
    end else begin
      st   <= nx;
      held <= (nx == S_HELD && st == S_HELD) ? held + 1'b1 : '0;
    end
  end

  assign dreq      = (st != S_IDLE);
  assign master_n  = !(st == S_HELD || st == S_NOCMD || st == S_NOADR);
  assign adr_drive = (st == S_HELD && held != '0) || st == S_NOCMD;
  assign cmd_allow = (st == S_HELD && held > CW'(1));

  logic [CW:0] low_run;
  always_ff @(posedge clk) begin
    if (rst) low_run <= '0;
    else if (master_n) low_run <= '0;
    else if (low_run <= (CW+1)'(HOLD_LIMIT)) low_run <= low_run + 1'b1;
  end

  // R7
  hold_limit_chk: assert property (@(posedge clk) disable iff (rst)
    low_run <= (CW+1)'(HOLD_LIMIT));

  // R5
  adr_after_claim_chk: assert property (@(posedge clk) disable iff (rst)
    adr_drive |-> (!master_n && $past(!master_n)));

  // R6
  cmd_after_claim_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_allow |-> (adr_drive && $past(!master_n) && $past(!master_n, 2)));

  // R3
  req_held_chk: assert property (@(posedge clk) disable iff (rst)
    !master_n |-> dreq);

  // R8
  release_master_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(master_n) |-> ($past(!adr_drive) && $past(!cmd_allow) && dreq));

  // R8
  release_adr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adr_drive) |-> (!cmd_allow && !master_n));

  // R8
  release_req_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dreq) |-> (master_n && $past(master_n)));

  // R9
  new_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dreq) |-> ($past(dack_n) && $past(want_bus)));

endmodule

// File: tb/cascade_master_test.sv
module cascade_master_test;
  localparam int LIM = 120;

  logic clk = 0, rst = 1, want_bus = 0, dack_n = 1;
  logic dreq, master_n, adr_drive, cmd_allow;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cascade_master #(.HOLD_LIMIT(LIM)) uut (
    .clk(clk), .rst(rst), .want_bus(want_bus), .dack_n(dack_n),
    .dreq(dreq), .master_n(master_n), .adr_drive(adr_drive), .cmd_allow(cmd_allow));

  function automatic logic [3:0] pack(logic r, logic m, logic a, logic c);
    return {r, m, a, c};
  endfunction

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(string req, logic [3:0] exp);
    logic [3:0] got;
    got = pack(dreq, master_n, adr_drive, cmd_allow);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got dreq/master_n/adr/cmd=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic chk_bit(string req, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    int low_cnt, run, prev_m, prev_m2, prev_a, prev_c, prev_r, seen_dk, seen_w, dly;
    void'($urandom(32'd1234));
    step(); step();
    chk("R1 in reset", pack(0, 1, 0, 0));
    rst = 0;
    step();
    chk("R1 after reset", pack(0, 1, 0, 0));

    want_bus = 1; dack_n = 1; step();
    chk("R2 request raised", pack(1, 1, 0, 0));
    want_bus = 0; step();
    chk("R3 request kept after local drop", pack(1, 1, 0, 0));
    step();
    chk("R3 request kept without ack", pack(1, 1, 0, 0));
    want_bus = 1; dack_n = 0; step();
    chk("R4 master claimed", pack(1, 0, 0, 0));
    step();
    chk("R5 addr one clock after claim", pack(1, 0, 1, 0));
    step();
    chk("R6 cmd two clocks after claim", pack(1, 0, 1, 1));
    want_bus = 0; step();
    chk("R10 R8 cmd off first", pack(1, 0, 1, 0));
    step();
    chk("R8 addr off second", pack(1, 0, 0, 0));
    step();
    chk("R8 master high third", pack(1, 1, 0, 0));
    step();
    chk("R8 request dropped last", pack(0, 1, 0, 0));
    want_bus = 1;
    step(); step();
    chk("R9 no request while ack active", pack(0, 1, 0, 0));
    dack_n = 1; step();
    chk("R9 request after ack inactive", pack(1, 1, 0, 0));

    dack_n = 0; step();
    low_cnt = 0;
    for (int i = 0; i < 3 * LIM && !master_n; i++) begin
      low_cnt++;
      step();
    end
    chk_bit("R7 hold time equals limit", low_cnt == LIM, 1'b1);
    chk("R7 R8 released with request still high", pack(1, 1, 0, 0));
    step();
    chk("R8 request dropped after forced release", pack(0, 1, 0, 0));
    dack_n = 1; want_bus = 0; step();

    // ack arrives while local request already dropped: short tenure
    want_bus = 1; step();
    want_bus = 0; dack_n = 0; step();
    chk("R4 claim even if local request gone", pack(1, 0, 0, 0));
    step();
    chk("R10 R5 release before commands", pack(1, 0, 1, 0));
    step(); step(); step();
    chk("R8 short tenure done", pack(0, 1, 0, 0));
    dack_n = 1; step();

    // random phase with a DMA controller model
    run = 0; prev_m = 1; prev_m2 = 1; prev_a = 0; prev_c = 0; prev_r = 0; dly = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) == 0) want_bus = ~want_bus;
      if (dly > 0) dly--;
      else if (dreq && dack_n) dly = $urandom_range(0, 4);
      else if (!dreq && !dack_n) dly = $urandom_range(0, 4);
      if (dly == 0) dack_n = !dreq;
      seen_dk = dack_n; seen_w = want_bus;
      step();
      run = master_n ? 0 : run + 1;
      if (run > LIM) chk_bit("R7 random hold over limit", 1'b0, 1'b1);
      if (adr_drive) chk_bit("R5 random addr early", !master_n && !prev_m, 1'b1);
      if (cmd_allow) chk_bit("R6 random cmd early", !prev_m && !prev_m2, 1'b1);
      if (prev_c && !seen_w) chk_bit("R10 random cmd stop", cmd_allow, 1'b0);
      if (master_n && !prev_m) chk_bit("R8 random master rise", prev_a || prev_c, 1'b0);
      if (dreq && !prev_r) chk_bit("R9 random request with ack high", seen_dk, 1);
      if (prev_r && prev_m && seen_dk) chk_bit("R3 random request held", dreq, 1'b1);
      prev_m2 = prev_m; prev_m = master_n; prev_a = adr_drive;
      prev_c = cmd_allow; prev_r = dreq;
    end
    done = 1;
    finish_run();
  end
endmodule